// File: doc/BRIEF.md
# Half-Warp Memory Access Coalescer

This block takes the load or store requests of one half-warp and turns them into a short list of aligned memory transactions. A half-warp has sixteen lanes. Each lane brings an active bit and a byte address, and every lane in the group uses the same access size. The group arrives on a request handshake. The block then issues its transactions one at a time on a transaction handshake. Each transaction carries an aligned base address, a byte count and a sixteen-bit mask of the lanes it serves. The memory side fetches the whole span and drops any bytes that no lane asked for.

Two flags arrive with each group:

- **Granularity flag.** Selects cached fetches of whole 128-byte lines, or uncached fetches of 32-byte pieces. The span a transaction covers, its granule, follows from this flag.
- **Rule flag.** Selects the strict rule or the relaxed rule. Under the strict rule, every active lane k must address word k of a region that is sixteen words long and aligned to its own size. If that holds, the lanes are grouped by granule. If it does not hold, each active lane gets a transaction of its own. Under the relaxed rule, any pattern is grouped by granule. This includes every lane reading the same address.

The controller has three states:

- **IDLE** accepts a group. The transition *accept* leads to EVAL. The transition *empty* stays in IDLE when no lane is active.
- **EVAL** spends one cycle judging the strict rule on the captured group. The transition *judge* leads to EMIT.
- **EMIT** offers the transaction of the lowest lane that has not yet been served. On handshake, the transition *issue* stays in EMIT while lanes remain. The transition *finish* returns to IDLE after the last lane is handed off.

Top module: `coalesce_unit`

## Requirements
- R1: After reset, req_ready is 1 and txn_valid is 0.
- R2: req_ready is 1 only in IDLE. A group with at least one active lane drops req_ready from the cycle after acceptance until the cycle after its last transaction is handed off. The first transaction is offered two cycles after the accepting edge.
- R3: The granule is 128 bytes when req_cached is 1 and 32 bytes when it is 0. txn_bytes equals the granule size, and txn_addr is the lead lane's address rounded down to a multiple of the granule.
- R4: Strict mode (req_relaxed=0) with word size W=2^req_size: the rule holds when some base B, aligned to 16*W, gives address B+k*W for every active lane k. Inactive lanes are ignored. A group that meets the rule is grouped by granule. For example, sixteen 4-byte lanes give one cached transaction, or two uncached ones.
- R5: In strict mode, a group that breaks the rule yields one transaction per active lane, in ascending lane order, each with a single-bit mask.
- R6: In relaxed mode (req_relaxed=1), each transaction takes the lowest unserved active lane as its lead. Its mask holds every unserved active lane whose address lies in the lead's granule. Transactions therefore come out in ascending order of lead lane.
- R7: Sixteen 16-byte lanes at consecutive words (req_size=4) with req_cached=1 need two transactions, covering lanes 0-7 and lanes 8-15.
- R8: A 4-byte group whose consecutive addresses straddle a 128-byte boundary yields two cached transactions in relaxed mode.
- R9: A group with no active lanes produces no transaction, and req_ready stays 1 in the following cycle.
- R10: While txn_valid is 1 and txn_ready is 0, txn_addr, txn_bytes and txn_mask hold and txn_valid stays 1.
- R11: Every transaction mask is non-zero, holds only active lanes and shares no lane with an earlier mask of the same group. Together the masks cover all active lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A half-warp group is offered |
| req_ready | output | 1 | The unit can take a group (IDLE) |
| req_active | input | 16 | Per-lane active bits, bit k for lane k |
| req_addr | input | 512 | Lane byte addresses, lane k in bits [32k+31:32k] |
| req_size | input | 3 | Word size code, bytes = 2^code, codes 0 to 4 |
| req_relaxed | input | 1 | 1 selects the relaxed rule, 0 the strict rule |
| req_cached | input | 1 | 1 selects 128-byte lines, 0 selects 32-byte pieces |
| txn_valid | output | 1 | A transaction is offered |
| txn_ready | input | 1 | The memory side takes the transaction |
| txn_addr | output | 32 | Granule-aligned base address |
| txn_bytes | output | 8 | Bytes fetched (128 or 32) |
| txn_mask | output | 16 | Lanes served by this transaction |

Lane addresses are expected to be aligned to the word size.

## Verification
The embedded properties check the following on every cycle:

- Offers stay stable under back-pressure (R10).
- Base addresses are aligned to the fetch size (R3).
- Split groups carry one-hot masks (R5).
- Masks are non-zero, contain only active lanes and never repeat a lane already served (R11).
- req_ready behaves correctly right after a group is accepted, for both empty and non-empty groups (R2, R9).

Some behaviour only the bench scenarios can show. These are the number of transactions a particular pattern costs, the order of the lead lanes, and the exact grouping under each mode combination. Examples are a broken strict pattern, a shared address, a straddled line and 16-byte words. The behavioural reference model supplies the expected transaction list and the cycle on which each entry must appear.

// File: rtl/coalesce_pkg.sv
package coalesce_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_EMIT = 2'd2
    } cu_state_e;

    localparam int SIZE_CODE_W = 3;
endpackage

// File: rtl/coalesce_strict_chk.sv
// Judges the strict lane-to-word rule: every active lane k must sit at
// word k of one region that is sixteen words long and aligned to its size.
module coalesce_strict_chk #(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic [LANES-1:0]        active,
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    input  logic [2:0]              size_code,
    output logic                    match
);
    logic [ADDR_W-1:0] cand [LANES];
    logic [ADDR_W-1:0] ref_cand;
    logic [ADDR_W-1:0] region_mask;
    logic              bad;

    // Base each lane implies: its address minus its own word offset.
    generate
        for (genvar k = 0; k < LANES; k++) begin : g_cand
            assign cand[k] = addr_flat[k*ADDR_W +: ADDR_W]
                           - (ADDR_W'(k) << size_code);
        end
    endgenerate

    always_comb begin
        region_mask = (ADDR_W'(1) << (LANE_W + 32'(size_code))) - ADDR_W'(1);
        ref_cand    = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (active[k]) ref_cand = cand[k];
        end
        bad = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            if (active[k] && (((cand[k] & region_mask) != '0) || (cand[k] != ref_cand)))
                bad = 1'b1;
        end
        match = !bad;
    end
endmodule

// File: rtl/coalesce_pick.sv
// Picks the lowest pending lane and gathers the lanes sharing its granule.
module coalesce_pick #(
    parameter int LANES      = 16,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    parameter int SEG_BYTES  = 32,
    parameter int LANE_W     = $clog2(LANES)
) (
    input  logic [LANES-1:0]        pending,
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    input  logic                    cached,
    input  logic                    split,
    output logic [LANE_W-1:0]       lead,
    output logic [ADDR_W-1:0]       base,
    output logic [LANES-1:0]        mask
);
    logic [ADDR_W-1:0] lane_addr [LANES];
    logic [ADDR_W-1:0] gran_mask;
    logic [LANES-1:0]  same;

    assign gran_mask = cached ? ADDR_W'(LINE_BYTES - 1) : ADDR_W'(SEG_BYTES - 1);

    always_comb begin
        lead = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (pending[k]) lead = LANE_W'(k);
        end
    end

    assign base = lane_addr[lead] & ~gran_mask;

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign lane_addr[k] = addr_flat[k*ADDR_W +: ADDR_W];
            assign same[k]      = pending[k] && ((lane_addr[k] & ~gran_mask) == base);
        end
    endgenerate

    assign mask = split ? (LANES'(1) << lead) : same;
endmodule

// File: rtl/coalesce_unit.sv
module coalesce_unit
    import coalesce_pkg::*;
#(
    parameter int LANES      = 16,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    parameter int SEG_BYTES  = 32,
    localparam int LANE_W    = $clog2(LANES),
    localparam int BYTES_W   = $clog2(LINE_BYTES) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES-1:0]        req_active,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [SIZE_CODE_W-1:0]  req_size,
    input  logic                    req_relaxed,
    input  logic                    req_cached,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_addr,
    output logic [BYTES_W-1:0]      txn_bytes,
    output logic [LANES-1:0]        txn_mask
);
    cu_state_e               state_q, state_d;
    logic [LANES-1:0]        active_q, pending_q, served_q;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [SIZE_CODE_W-1:0]  size_q;
    logic                    relaxed_q, cached_q, split_q;
    logic                    strict_ok;
    logic [LANE_W-1:0]       pick_lead;
    logic [ADDR_W-1:0]       pick_base;
    logic [LANES-1:0]        pick_mask;
    logic                    accept, handoff, last_one;

    coalesce_strict_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_strict (
        .active    (active_q),
        .addr_flat (addr_q),
        .size_code (size_q),
        .match     (strict_ok)
    );

    coalesce_pick #(.LANES(LANES), .ADDR_W(ADDR_W),
                    .LINE_BYTES(LINE_BYTES), .SEG_BYTES(SEG_BYTES)) u_pick (
        .pending   (pending_q),
        .addr_flat (addr_q),
        .cached    (cached_q),
        .split     (split_q),
        .lead      (pick_lead),
        .base      (pick_base),
        .mask      (pick_mask)
    );

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign handoff  = txn_ready && (state_q == ST_EMIT);
    assign last_one = (pending_q & ~pick_mask) == '0;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && (req_active != '0)) state_d = ST_EVAL;   // accept / empty
            ST_EVAL: state_d = ST_EMIT;                                     // judge
            ST_EMIT: if (handoff && last_one) state_d = ST_IDLE;           // issue / finish
            default: state_d = ST_IDLE;
        endcase
    end

    // State and group registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            active_q  <= '0;
            pending_q <= '0;
            served_q  <= '0;
            addr_q    <= '0;
            size_q    <= '0;
            relaxed_q <= 1'b0;
            cached_q  <= 1'b0;
            split_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                active_q  <= req_active;
                pending_q <= req_active;
                served_q  <= '0;
                addr_q    <= req_addr;
                size_q    <= req_size;
                relaxed_q <= req_relaxed;
                cached_q  <= req_cached;
            end
            if (state_q == ST_EVAL) split_q <= !relaxed_q && !strict_ok;
            if (handoff) begin
                pending_q <= pending_q & ~pick_mask;
                served_q  <= served_q | pick_mask;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        txn_valid = (state_q == ST_EMIT);
        txn_addr  = pick_base;
        txn_bytes = cached_q ? BYTES_W'(LINE_BYTES) : BYTES_W'(SEG_BYTES);
        txn_mask  = pick_mask;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_addr) && $stable(txn_mask) && $stable(txn_bytes))); // R10
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_active != '0)) |=> !req_ready); // R2
    AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_active == '0)) |=> (req_ready && !txn_valid)); // R9
    AST_SPLIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && split_q) |-> $onehot(txn_mask)); // R5
    AST_MASK_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_mask != '0) && ((txn_mask & served_q) == '0) && ((txn_mask & ~active_q) == '0))); // R11
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_addr & (ADDR_W'(txn_bytes) - ADDR_W'(1))) == '0)); // R3
    AST_LEAD_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> txn_mask[pick_lead]); // R6
endmodule

// File: tb/sim_coalesce_unit.sv
module sim_coalesce_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_active = '0;
    logic [511:0] req_addr;
    logic [2:0]  req_size = '0;
    logic        req_relaxed = 1'b0;
    logic        req_cached = 1'b0;
    logic        txn_valid;
    logic        txn_ready = 1'b1;
    logic [31:0] txn_addr;
    logic [7:0]  txn_bytes;
    logic [15:0] txn_mask;

    logic [31:0] b_addr [16];
    int checks = 0;
    int errors = 0;
    int phase = 0;            // model: 0 idle, 1 judging, 2 emitting
    int hs_count = 0;
    logic [15:0] union_mask = '0;
    logic        overlap = 1'b0;
    int bp_mode = 0;
    logic [31:0] q_addr [$];
    logic [15:0] q_mask [$];
    int          q_bytes [$];
    bit          finished = 0;

    always #4 clk = ~clk;

    generate
        for (genvar k = 0; k < 16; k++) begin : g_flat
            assign req_addr[k*32 +: 32] = b_addr[k];
        end
    endgenerate

    coalesce_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_active(req_active), .req_addr(req_addr), .req_size(req_size),
        .req_relaxed(req_relaxed), .req_cached(req_cached), .txn_valid(txn_valid),
        .txn_ready(txn_ready), .txn_addr(txn_addr), .txn_bytes(txn_bytes),
        .txn_mask(txn_mask)
    );

    // Behavioural reference: expected transaction list for the offered group
    task automatic build_list();
        int w, g, f;
        logic [31:0] b;
        bit ok, split;
        logic [15:0] left, m;
        w = 1 << req_size;
        g = req_cached ? 128 : 32;
        f = -1;
        for (int k = 0; k < 16; k++) if (req_active[k] && f < 0) f = k;
        ok = 1;
        if (f >= 0) begin
            b = b_addr[f] - 32'(f * w);
            if ((b % (16 * w)) != 0) ok = 0;
            for (int k = 0; k < 16; k++)
                if (req_active[k] && (b_addr[k] - 32'(k * w) != b)) ok = 0;
        end
        split = !req_relaxed && !ok;
        left = req_active;
        while (left != 0) begin
            int l;
            l = -1;
            for (int k = 0; k < 16; k++) if (left[k] && l < 0) l = k;
            m = '0;
            if (split) m[l] = 1'b1;
            else
                for (int k = 0; k < 16; k++)
                    if (left[k] && (b_addr[k] / g == b_addr[l] / g)) m[k] = 1'b1;
            q_addr.push_back(b_addr[l] / g * g);
            q_mask.push_back(m);
            q_bytes.push_back(g);
            left = left & ~m;
        end
    endtask

    // Per-cycle comparison and model advance, at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (req_ready !== (phase == 0)) begin
                errors++;
                $display("FAIL R2 req_ready act=%0b exp=%0b", req_ready, phase == 0);
            end
            checks++;
            if (txn_valid !== (phase == 2)) begin
                errors++;
                $display("FAIL R2 txn_valid act=%0b exp=%0b", txn_valid, phase == 2);
            end
            if (phase == 2 && q_addr.size() > 0) begin
                checks++;
                if (txn_addr !== q_addr[0] || txn_mask !== q_mask[0] || int'(txn_bytes) != q_bytes[0]) begin
                    errors++;
                    $display("FAIL R6 txn act=%h/%h/%0d exp=%h/%h/%0d", txn_addr, txn_mask,
                             txn_bytes, q_addr[0], q_mask[0], q_bytes[0]);
                end
            end
            if (txn_valid && txn_ready) begin
                hs_count++;
                if ((union_mask & txn_mask) != 0) overlap = 1'b1;
                union_mask = union_mask | txn_mask;
            end
            case (phase)
                0: if (req_valid) begin
                       build_list();
                       if (q_addr.size() > 0) phase = 1;
                   end
                1: phase = 2;
                default: if (txn_ready) begin
                       void'(q_addr.pop_front());
                       void'(q_mask.pop_front());
                       void'(q_bytes.pop_front());
                       if (q_addr.size() == 0) phase = 0;
                   end
            endcase
        end
    end

    // Consumer readiness pattern
    initial begin
        int cyc;
        cyc = 0;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            txn_ready = (bp_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
        end
    end

    task automatic check_val(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic send(string tag, logic [15:0] act, logic [2:0] sz, logic rlx,
                        logic cch, int exp_n);
        @(posedge clk);
        #1;
        req_active  = act;
        req_size    = sz;
        req_relaxed = rlx;
        req_cached  = cch;
        req_valid   = 1'b1;
        hs_count    = 0;
        union_mask  = '0;
        overlap     = 1'b0;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        forever begin
            @(negedge clk);
            #1;
            if (phase == 0) break;
        end
        @(negedge clk);
        check_val({tag, " count"}, hs_count, exp_n);
        check_val("R11 union", int'(union_mask), int'(act));
        check_val("R11 overlap", int'(overlap), 0);
    endtask

    task automatic fill_linear(logic [31:0] base, int w);
        for (int k = 0; k < 16; k++) b_addr[k] = base + 32'(k * w);
    endtask

    initial begin
        fill_linear(32'h0, 4);
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        checks++;
        if (req_ready !== 1'b1 || txn_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset act=%0b%0b exp=10", req_ready, txn_valid);
        end
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        fill_linear(32'h1000, 4);
        send("R4 strict cached", 16'hFFFF, 3'd2, 1'b0, 1'b1, 1);
        send("R3 strict uncached", 16'hFFFF, 3'd2, 1'b0, 1'b0, 2);
        b_addr[3] = 32'hDEAD_0000;
        b_addr[7] = 32'h0BAD_0004;
        send("R4 inactive lanes ignored", 16'hFF77, 3'd2, 1'b0, 1'b1, 1);
        fill_linear(32'h1000, 4);
        b_addr[0] = 32'h1004;
        b_addr[1] = 32'h1000;
        send("R5 strict broken", 16'hFFFF, 3'd2, 1'b0, 1'b1, 16);
        send("R6 relaxed permuted", 16'hFFFF, 3'd2, 1'b1, 1'b1, 1);
        for (int k = 0; k < 16; k++) b_addr[k] = 32'h2040;
        send("R6 relaxed same address", 16'hFFFF, 3'd2, 1'b1, 1'b1, 1);
        fill_linear(32'h3060, 4);
        send("R8 straddle relaxed", 16'hFFFF, 3'd2, 1'b1, 1'b1, 2);
        send("R5 straddle strict", 16'hFFFF, 3'd2, 1'b0, 1'b1, 16);
        fill_linear(32'h4000, 16);
        send("R7 16-byte words", 16'hFFFF, 3'd4, 1'b0, 1'b1, 2);
        send("R9 empty group", 16'h0000, 3'd2, 1'b1, 1'b1, 0);
        for (int k = 0; k < 16; k++) b_addr[k] = 32'h5000 + 32'(128 * (k % 4) + k);
        send("R6 scattered bytes", 16'hFFFF, 3'd0, 1'b1, 1'b1, 4);
        bp_mode = 1;
        send("R10 backpressure scattered", 16'hFFFF, 3'd0, 1'b1, 1'b0, 4);
        fill_linear(32'h1000, 4);
        send("R10 backpressure split", 16'h8421, 3'd2, 1'b0, 1'b1, 1);
        b_addr[5] = 32'h7777_0000;
        send("R5 backpressure sparse break", 16'h00F0, 3'd2, 1'b0, 1'b0, 4);
        bp_mode = 0;

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule